// File: doc/BRIEF.md
# DRAM Refresh and Power-Up Sequencer

This block keeps an asynchronous DRAM alive. After reset it waits out the power-up pause. It then runs a fixed number of wake-up cycles before it reports the memory usable. From then on it schedules one refresh per refresh interval. Every refresh is a column-strobe-first cycle, so the memory's own row counter picks the row and no address is driven. All durations are parameters counted in clock cycles.

The sequencer shares the memory bus with an access controller. It raises a request whenever refreshes are owed and the sequencer is idle. A cycle starts on the first clock edge where the request and the grant are both high. While a cycle runs, the sequencer owns the strobes and reports busy. Refreshes that cannot be served at once are counted in a saturating backlog. Once the backlog reaches a threshold, an urgency flag tells the arbiter to stop postponing.

No data moves through this block, so there is no valid/ready stream. The request and grant pair is a plain level handshake. The grant is sampled only in the idle state, and withdrawing it stalls nothing that has already started.

Top module: `dram_refresh_seq`

## Requirements
- R1: While reset is asserted, and right after an asynchronous reset arrives mid-cycle, both strobes and the write enable are high and `ready_o`, `req_o`, `busy_o` and `urgent_o` are low.
- R2: No strobe moves during the first `PWRUP_CYC` cycles after reset. Then exactly `INIT_CYCLES` refresh cycles are run, and `ready_o` rises at the completion of the last of them and stays high until the next reset.
- R3: In each refresh cycle the column strobe falls and the row strobe follows exactly `COL_LEAD_CYC` cycles later. The column strobe rises `COL_HOLD_CYC` cycles after the row strobe falls. The row strobe is low for exactly `ROW_LOW_CYC` cycles, and the column strobe is already high when the row strobe rises.
- R4: After the row strobe rises, both strobes stay high for at least `ROW_PRE_CYC` cycles before the next column strobe fall.
- R5: The write enable output (`wr_en_n_o`, active low) is high at all times, so no refresh cycle can be read by the memory as a test-mode entry.
- R6: A refresh cycle starts only from idle, at an edge where `req_o` and `grant_i` are both high. Once started, it runs to completion whatever `grant_i` does. `busy_o` covers the whole cycle, and the strobes are low only while `busy_o` is high.
- R7: Once `ready_o` is high, one refresh becomes owed every `REFI_CYC` cycles and each completed cycle pays one off. `req_o` is high exactly when the sequencer is idle and at least one refresh is owed.
- R8: `urgent_o` is high whenever the owed count is `URGENT_TH` or more.
- R9: The owed count saturates at `BACKLOG_MAX`. Interval expiries beyond that are dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| grant_i | input | 1 | Bus granted to the sequencer by the access arbiter |
| ready_o | output | 1 | Power-up pause and wake-up cycles are complete |
| req_o | output | 1 | Idle with refreshes owed; asks for the bus |
| urgent_o | output | 1 | Owed count has reached the urgency threshold |
| busy_o | output | 1 | Sequencer owns the strobes |
| row_stb_n_o | output | 1 | Row strobe, active low |
| col_stb_n_o | output | 1 | Column strobe, active low |
| wr_en_n_o | output | 1 | Write enable, active low, held high |

## Verification
The checker watches every clock for the strobe order inside a cycle: the column strobe low before the row strobe falls, and high again when it rises. It also checks the row-strobe low width and the precharge gap with its own counters, that strobes move only while busy, that busy begins only after a granted request, that urgency implies outstanding work, and that ready never drops. The bench scenarios are needed for the counting behaviour, which no single-cycle property sees. That covers how many wake-up cycles precede ready, the exact number of refreshes accumulated across a held-off window, the urgency boundary, backlog saturation, a one-cycle grant that still yields a full cycle, and recovery from a reset taken in mid-cycle.

// File: rtl/dram_rfsh_pkg.sv
package dram_rfsh_pkg;
  typedef enum logic [1:0] {
    CY_IDLE  = 2'd0,
    CY_SETUP = 2'd1,
    CY_ROW   = 2'd2,
    CY_PRE   = 2'd3
  } cyc_state_e;
endpackage

// File: rtl/rfsh_interval_timer.sv
module rfsh_interval_timer #(
  parameter int REFI_CYC = 3900
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  output logic tick_o
);
  localparam int TW = (REFI_CYC > 1) ? $clog2(REFI_CYC) : 1;
  localparam logic [TW-1:0] LAST = TW'(REFI_CYC - 1);

  logic [TW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= '0;
    else if (!run_i)     cnt <= '0;
    else if (cnt == LAST) cnt <= '0;
    else                 cnt <= cnt + 1'b1;
  end

  assign tick_o = run_i && (cnt == LAST);
endmodule

// File: rtl/rfsh_backlog.sv
module rfsh_backlog #(
  parameter int BACKLOG_MAX = 15,
  parameter int INIT_CYCLES = 8,
  localparam int OW = $clog2(BACKLOG_MAX + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_init_i,
  input  logic          tick_i,
  input  logic          done_i,
  output logic [OW-1:0] owed_o
);
  localparam logic [OW-1:0] FULL = OW'(BACKLOG_MAX);
  localparam logic [OW-1:0] INIT = OW'(INIT_CYCLES);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      owed_o <= '0;
    end else if (load_init_i) begin
      owed_o <= INIT;
    end else if (tick_i && !done_i) begin
      if (owed_o != FULL) owed_o <= owed_o + 1'b1;
    end else if (done_i && !tick_i) begin
      if (owed_o != '0) owed_o <= owed_o - 1'b1;
    end
  end
endmodule

// File: rtl/rfsh_cycle_fsm.sv
module rfsh_cycle_fsm
  import dram_rfsh_pkg::*;
#(
  parameter int COL_LEAD_CYC = 3,
  parameter int COL_HOLD_CYC = 3,
  parameter int ROW_LOW_CYC  = 13,
  parameter int ROW_PRE_CYC  = 9
) (
  input  logic clk,
  input  logic rst_n,
  input  logic go_i,
  output logic row_stb_n_o,
  output logic col_stb_n_o,
  output logic busy_o,
  output logic done_o
);
  localparam int MAXC = (ROW_LOW_CYC > ROW_PRE_CYC) ?
                        ((ROW_LOW_CYC > COL_LEAD_CYC) ? ROW_LOW_CYC : COL_LEAD_CYC) :
                        ((ROW_PRE_CYC > COL_LEAD_CYC) ? ROW_PRE_CYC : COL_LEAD_CYC);
  localparam int CW = $clog2(MAXC + 1);
  localparam logic [CW-1:0] LEAD_LAST = CW'(COL_LEAD_CYC - 1);
  localparam logic [CW-1:0] LOW_LAST  = CW'(ROW_LOW_CYC - 1);
  localparam logic [CW-1:0] PRE_LAST  = CW'(ROW_PRE_CYC - 1);
  localparam logic [CW-1:0] HOLD_END  = CW'(COL_HOLD_CYC);

  cyc_state_e    st;
  logic [CW-1:0] cnt;
  logic [CW-1:0] last;

  always_comb begin
    unique case (st)
      CY_SETUP: last = LEAD_LAST;
      CY_ROW:   last = LOW_LAST;
      CY_PRE:   last = PRE_LAST;
      default:  last = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st  <= CY_IDLE;
      cnt <= '0;
    end else if (st == CY_IDLE) begin
      cnt <= '0;
      if (go_i) st <= CY_SETUP;
    end else if (cnt == last) begin
      cnt <= '0;
      unique case (st)
        CY_SETUP: st <= CY_ROW;
        CY_ROW:   st <= CY_PRE;
        default:  st <= CY_IDLE;
      endcase
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  assign busy_o      = (st != CY_IDLE);
  assign row_stb_n_o = (st != CY_ROW);
  assign col_stb_n_o = !((st == CY_SETUP) || ((st == CY_ROW) && (cnt < HOLD_END)));
  assign done_o      = (st == CY_PRE) && (cnt == PRE_LAST);
endmodule

// File: rtl/dram_refresh_seq.sv
module dram_refresh_seq #(
  parameter int PWRUP_CYC    = 50000,
  parameter int INIT_CYCLES  = 8,
  parameter int REFI_CYC     = 3900,
  parameter int URGENT_TH    = 8,
  parameter int BACKLOG_MAX  = 15,
  parameter int COL_LEAD_CYC = 3,
  parameter int COL_HOLD_CYC = 3,
  parameter int ROW_LOW_CYC  = 13,
  parameter int ROW_PRE_CYC  = 9
) (
  input  logic clk,
  input  logic rst_n,
  input  logic grant_i,
  output logic ready_o,
  output logic req_o,
  output logic urgent_o,
  output logic busy_o,
  output logic row_stb_n_o,
  output logic col_stb_n_o,
  output logic wr_en_n_o
);
  localparam int PW = $clog2(PWRUP_CYC + 1);
  localparam int OW = $clog2(BACKLOG_MAX + 1);
  localparam logic [PW-1:0] PW_LAST = PW'(PWRUP_CYC - 1);
  localparam logic [OW-1:0] URG     = OW'(URGENT_TH);
  localparam logic [OW-1:0] ONE     = OW'(1);

  logic [PW-1:0] pwr_cnt;
  logic          pwr_done;
  logic          init_active;
  logic          load_init;
  logic          tick;
  logic          done;
  logic [OW-1:0] owed;

  assign load_init = !pwr_done && (pwr_cnt == PW_LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pwr_cnt     <= '0;
      pwr_done    <= 1'b0;
      init_active <= 1'b0;
    end else begin
      if (!pwr_done) pwr_cnt <= pwr_cnt + 1'b1;
      if (load_init) begin
        pwr_done    <= 1'b1;
        init_active <= 1'b1;
      end else if (init_active && done && (owed == ONE)) begin
        init_active <= 1'b0;
      end
    end
  end

  assign ready_o   = pwr_done && !init_active;
  assign req_o     = (owed != '0) && !busy_o;
  assign urgent_o  = (owed >= URG);
  assign wr_en_n_o = 1'b1;

  rfsh_interval_timer #(.REFI_CYC(REFI_CYC)) u_timer (
    .clk(clk), .rst_n(rst_n), .run_i(ready_o), .tick_o(tick)
  );

  rfsh_backlog #(.BACKLOG_MAX(BACKLOG_MAX), .INIT_CYCLES(INIT_CYCLES)) u_backlog (
    .clk(clk), .rst_n(rst_n), .load_init_i(load_init),
    .tick_i(tick), .done_i(done), .owed_o(owed)
  );

  rfsh_cycle_fsm #(
    .COL_LEAD_CYC(COL_LEAD_CYC), .COL_HOLD_CYC(COL_HOLD_CYC),
    .ROW_LOW_CYC(ROW_LOW_CYC), .ROW_PRE_CYC(ROW_PRE_CYC)
  ) u_fsm (
    .clk(clk), .rst_n(rst_n), .go_i(req_o && grant_i),
    .row_stb_n_o(row_stb_n_o), .col_stb_n_o(col_stb_n_o),
    .busy_o(busy_o), .done_o(done)
  );
endmodule

// File: rtl/dram_refresh_seq_chk.sv
module dram_refresh_seq_chk #(
  parameter int ROW_LOW_CYC = 13,
  parameter int ROW_PRE_CYC = 9
) (
  input logic clk,
  input logic rst_n,
  input logic grant_i,
  input logic ready_o,
  input logic req_o,
  input logic urgent_o,
  input logic busy_o,
  input logic row_stb_n_o,
  input logic col_stb_n_o
);
  localparam int LW = $clog2(ROW_LOW_CYC + 2);
  localparam int HW = $clog2(ROW_PRE_CYC + 1);
  localparam logic [LW-1:0] LOW_N = LW'(ROW_LOW_CYC);
  localparam logic [LW-1:0] LOW_SAT = LW'(ROW_LOW_CYC + 1);
  localparam logic [HW-1:0] PRE_N = HW'(ROW_PRE_CYC);

  logic [LW-1:0] lo_cnt;
  logic [HW-1:0] hi_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_cnt <= '0;
      hi_cnt <= PRE_N;
    end else begin
      if (!row_stb_n_o) begin
        if (lo_cnt != LOW_SAT) lo_cnt <= lo_cnt + 1'b1;
        hi_cnt <= '0;
      end else begin
        lo_cnt <= '0;
        if (hi_cnt != PRE_N) hi_cnt <= hi_cnt + 1'b1;
      end
    end
  end

  assert_col_leads_row_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(row_stb_n_o) |-> (!col_stb_n_o && $past(!col_stb_n_o)));

  assert_col_high_at_row_rise_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(row_stb_n_o) |-> col_stb_n_o);

  assert_row_width_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(row_stb_n_o) |-> (lo_cnt == LOW_N));

  assert_precharge_gap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(row_stb_n_o) |-> (hi_cnt == PRE_N));

  assert_strobes_owned_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!row_stb_n_o || !col_stb_n_o) |-> busy_o);

  assert_start_granted_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |-> ($past(grant_i) && $past(req_o)));

  assert_urgent_pending_R8: assert property (@(posedge clk) disable iff (!rst_n)
    urgent_o |-> (req_o || busy_o));

  assert_ready_sticky_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ready_o |=> ready_o);
endmodule

bind dram_refresh_seq dram_refresh_seq_chk #(
  .ROW_LOW_CYC(ROW_LOW_CYC), .ROW_PRE_CYC(ROW_PRE_CYC)
) u_chk (
  .clk(clk), .rst_n(rst_n), .grant_i(grant_i), .ready_o(ready_o),
  .req_o(req_o), .urgent_o(urgent_o), .busy_o(busy_o),
  .row_stb_n_o(row_stb_n_o), .col_stb_n_o(col_stb_n_o)
);

// File: tb/sim_dram_refresh_seq.sv
`timescale 1ns/1ps
module sim_dram_refresh_seq;
  localparam int PWRUP = 40;
  localparam int INIT  = 8;
  localparam int REFI  = 400;
  localparam int URG   = 8;
  localparam int BMAX  = 12;
  localparam int LEAD  = 3;
  localparam int HOLD  = 3;
  localparam int RLOW  = 13;
  localparam int RPRE  = 9;
  localparam int WATCHDOG = 150000;

  // each row: cycles-held-off in intervals, expected urgent, expected minimum serviced
  localparam int NVEC = 5;
  localparam int VEC [NVEC][3] = '{'{1,0,1}, '{3,0,3}, '{7,0,7}, '{8,1,8}, '{14,1,12}};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic grant = 1'b0;
  logic ready_o, req_o, urgent_o, busy_o, row_n, col_n, we_n;

  always #2 clk = ~clk;

  dram_refresh_seq #(
    .PWRUP_CYC(PWRUP), .INIT_CYCLES(INIT), .REFI_CYC(REFI), .URGENT_TH(URG),
    .BACKLOG_MAX(BMAX), .COL_LEAD_CYC(LEAD), .COL_HOLD_CYC(HOLD),
    .ROW_LOW_CYC(RLOW), .ROW_PRE_CYC(RPRE)
  ) u0 (
    .clk(clk), .rst_n(rst_n), .grant_i(grant), .ready_o(ready_o), .req_o(req_o),
    .urgent_o(urgent_o), .busy_o(busy_o), .row_stb_n_o(row_n),
    .col_stb_n_o(col_n), .wr_en_n_o(we_n)
  );

  int n_chk = 0;
  int n_bad = 0;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d @%0t", tag, act, exp, $time);
    end
  endtask

  // strobe monitor
  int  cyc = 0;
  int  t_cf = 0, t_rf = 0, t_rr = 0, first_cf = -1, pulses = 0;
  bit  have_rr = 0, we_bad = 0, own_bad = 0;
  logic pr = 1'b1, pc = 1'b1, prdy = 1'b0;

  always @(negedge clk) begin
    if (!rst_n) begin
      cyc = 0; have_rr = 0; pulses = 0; first_cf = -1;
      pr = 1'b1; pc = 1'b1; prdy = 1'b0;
    end else begin
      cyc++;
      if (pc && !col_n && row_n) begin
        t_cf = cyc;
        if (first_cf < 0) first_cf = cyc;
        if (have_rr) check(cyc - t_rr >= RPRE, "R4 precharge gap", cyc - t_rr, RPRE);
      end
      if (pr && !row_n) begin
        check(cyc - t_cf == LEAD, "R3 column lead", cyc - t_cf, LEAD);
        check(!col_n, "R3 column low at row fall", int'(col_n), 0);
        t_rf = cyc;
      end
      if (!pc && col_n && !row_n)
        check(cyc - t_rf == HOLD, "R3 column hold", cyc - t_rf, HOLD);
      if (!pr && row_n) begin
        check(cyc - t_rf == RLOW, "R3 row low width", cyc - t_rf, RLOW);
        check(col_n == 1'b1, "R3 column high at row rise", int'(col_n), 1);
        t_rr = cyc; have_rr = 1; pulses++;
      end
      if (ready_o && !prdy)
        check(pulses == INIT, "R2 wake-up cycles before ready", pulses, INIT);
      if (!ready_o && prdy)
        check(0, "R2 ready dropped", 0, 1);
      if (we_n !== 1'b1) we_bad = 1;
      if ((!row_n || !col_n) && !busy_o) own_bad = 1;
      pr = row_n; pc = col_n; prdy = ready_o;
    end
  end

  // watchdog
  int tot = 0;
  always @(posedge clk) begin
    tot++;
    if (tot > WATCHDOG) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired actual=%0d expected<=%0d", tot, WATCHDOG);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  task automatic drain();
    grant = 1'b1;
    do @(negedge clk); while (!(ready_o && !req_o && !busy_o));
  endtask

  task automatic check_idle_outputs(input string tag);
    check(row_n && col_n && we_n, {tag, " strobes high"}, {29'd0, row_n, col_n, we_n}, 7);
    check(!ready_o && !req_o && !busy_o && !urgent_o, {tag, " flags low"},
          {28'd0, ready_o, req_o, busy_o, urgent_o}, 0);
  endtask

  initial begin
    #1;
    check_idle_outputs("R1 in reset");
    repeat (3) @(negedge clk);
    #1 rst_n = 1'b1;
    grant = 1'b1;

    // R2: power-up pause then wake-up cycles
    do @(negedge clk); while (!ready_o);
    check(first_cf >= PWRUP && first_cf <= PWRUP + 2, "R2 first strobe after pause", first_cf, PWRUP + 1);
    check(pulses == INIT, "R2 cycles at ready", pulses, INIT);

    // table walk: R7 accumulation, R8 urgency, R9 saturation
    for (int v = 0; v < NVEC; v++) begin
      int k, base, served;
      k = VEC[v][0];
      drain();
      grant = 1'b0;
      base = pulses;
      repeat (k * REFI) @(posedge clk);
      @(negedge clk);
      check(pulses == base && !busy_o, "R6 no cycle without grant", pulses - base, 0);
      check(req_o == 1'b1, "R7 request after held-off interval", int'(req_o), 1);
      check(urgent_o == VEC[v][1], "R8 urgency at boundary", int'(urgent_o), VEC[v][1]);
      drain();
      served = pulses - base;
      check(served >= VEC[v][2] && served <= VEC[v][2] + 1, "R7 R9 refreshes served",
            served, VEC[v][2]);
    end

    // R6: one-cycle grant still yields one full cycle
    begin
      int base;
      grant = 1'b0;
      do @(negedge clk); while (!req_o);
      base = pulses;
      grant = 1'b1;
      @(negedge clk);
      grant = 1'b0;
      check(busy_o == 1'b1, "R6 cycle started on grant", int'(busy_o), 1);
      do @(negedge clk); while (busy_o);
      check(pulses == base + 1, "R6 cycle completed after grant drop", pulses - base, 1);
      check(!req_o, "R7 request cleared after payment", int'(req_o), 0);
    end

    // R1: reset in the middle of a cycle
    grant = 1'b1;
    do @(negedge clk); while (row_n);
    rst_n = 1'b0;
    #1;
    check_idle_outputs("R1 mid-cycle reset");
    @(negedge clk);
    #1 rst_n = 1'b1;
    do @(negedge clk); while (!ready_o);
    check(pulses == INIT, "R2 wake-up after second reset", pulses, INIT);

    check(!we_bad, "R5 write enable always high", int'(we_bad), 0);
    check(!own_bad, "R6 strobes only while busy", int'(own_bad), 0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule